// File: doc/BRIEF.md
# Load-Use Interlock Detector

This block sits beside the decode stage of a five-stage in-order pipeline and detects the single case that forwarding cannot cover. That case is a load still in the execute stage whose result is needed by the instruction now being decoded. The block reads two instruction words: the copy held in the ID/EX pipeline register (the possible producer) and the copy held in IF/ID (the possible consumer). It decodes the opcode and register fields of each word directly.

On a hazard, the block drops the write enables of the program counter and of IF/ID, so both keep their values. In the same cycle it raises a bubble select, which makes ID/EX capture a no-operation at the next edge. Which consumer register fields count as sources depends on the consumer's instruction class. A small registered flag limits each interlock to a single cycle.

Top module: `ldu_interlock`

## Requirements
- R1: While rst_n is low, the outputs show no stall (pc_write=1, ifid_write=1, idex_bubble=0), whatever the instruction inputs are.
- R2: A stall is possible only when the opcode field, bits 31:26 of idex_instr, equals 0x23 (load). Any other value in those bits never stalls, even when the register fields match.
- R3: With a load in ID/EX, a stall is raised when the load's rt field (bits 20:16) equals the rs field (bits 25:21) of ifid_instr. This applies when the consumer opcode is R-type 0x00, immediate ALU 0x08 to 0x0F, load 0x23, store 0x2B, or branch 0x04/0x05.
- R4: With a load in ID/EX, a stall is also raised when the load's rt equals the consumer's rt field (bits 20:16), for R-type, store and branch consumers.
- R5: A match of the load's rt with the rt field of an immediate-ALU or load consumer does not stall, because that field is the consumer's destination.
- R6: A load whose rt field is 0 never causes a stall.
- R7: The three outputs move together. In a stall cycle they are pc_write=0, ifid_write=0 and idex_bubble=1. In every other cycle they are 1, 1, 0.
- R8: A stall lasts exactly one cycle. In the cycle after a stall cycle no stall is raised, even if the inputs still show a hazard. A hazard in the cycle after that stalls again.
- R9: A consumer whose opcode is outside the source-reading classes listed in R3 (for example 0x02, 0x07 or 0x10) never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ifid_instr | input | 32 | Instruction word held in IF/ID (consumer) |
| idex_instr | input | 32 | Instruction word held in ID/EX (producer) |
| pc_write | output | 1 | Program counter write enable, low to hold |
| ifid_write | output | 1 | IF/ID write enable, low to hold |
| idex_bubble | output | 1 | High to load a no-operation into ID/EX at the next edge |

## Verification
The assertions assume the two instruction words are stable and known through each clock cycle. They also assume that a stall cycle is followed by one cycle in which a surrounding pipeline would have put a bubble into ID/EX.

The stimulus changes its inputs only at the falling edge. Between table vectors it inserts a cycle of all-zero words, so that no vector falls under the one-cycle suppression. Only the directed test aimed at that suppression holds a hazard across consecutive edges.

// File: rtl/ldu_pkg.sv
// Package: shared constants, field positions and the decoded-instruction type
// for the load-use interlock. Assumes a fixed 32-bit three-register format.
package ldu_pkg;
    localparam int INSTR_W = 32;
    localparam int OP_W    = 6;
    localparam int REG_W   = 5;
    localparam int OP_LSB  = INSTR_W - OP_W;
    localparam int RS_LSB  = OP_LSB - REG_W;
    localparam int RT_LSB  = RS_LSB - REG_W;

    localparam logic [OP_W-1:0] OPC_RTYPE  = 6'h00;
    localparam logic [OP_W-1:0] OPC_BEQ    = 6'h04;
    localparam logic [OP_W-1:0] OPC_BNE    = 6'h05;
    localparam logic [OP_W-1:0] OPC_IMM_LO = 6'h08;
    localparam logic [OP_W-1:0] OPC_IMM_HI = 6'h0F;
    localparam logic [OP_W-1:0] OPC_LOAD   = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE  = 6'h2B;

    typedef struct packed {
        logic             is_load;
        logic             src_rs;
        logic             src_rt;
        logic [REG_W-1:0] rs;
        logic [REG_W-1:0] rt;
    } dec_t;
endpackage

// File: rtl/ldu_decode.sv
// Decoder: splits one instruction word into register fields and flags that
// say whether it is a load and which of rs/rt it reads as sources.
// Assumes the opcode occupies the top OP_W bits of the word.
module ldu_decode
    import ldu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [OP_W-1:0] opc;
    logic            cls_r, cls_br, cls_imm, cls_ld, cls_st;

    // Classify the opcode into instruction groups.
    always_comb begin
        opc     = instr[INSTR_W-1 -: OP_W];
        cls_r   = (opc == OPC_RTYPE);
        cls_br  = (opc == OPC_BEQ) || (opc == OPC_BNE);
        cls_imm = (opc >= OPC_IMM_LO) && (opc <= OPC_IMM_HI);
        cls_ld  = (opc == OPC_LOAD);
        cls_st  = (opc == OPC_STORE);
    end

    // Build the decoded record; rt is a source only for R-type, store, branch.
    always_comb begin
        dec.is_load = cls_ld;
        dec.src_rs  = cls_r | cls_br | cls_imm | cls_ld | cls_st;
        dec.src_rt  = cls_r | cls_br | cls_st;
        dec.rs      = instr[RS_LSB +: REG_W];
        dec.rt      = instr[RT_LSB +: REG_W];
    end
endmodule

// File: rtl/ldu_match.sv
// Comparator: raises hazard when a load producer's destination (rt, nonzero)
// equals any register the consumer reads. Purely combinational.
module ldu_match
    import ldu_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input  dec_t prod,
    input  dec_t cons,
    output logic hazard
);
    logic [N_SRC-1:0]       hit;
    logic [REG_W-1:0]       src_reg [N_SRC];
    logic [N_SRC-1:0]       src_en;

    // Gather the consumer's candidate source operands.
    always_comb begin
        src_reg[0] = cons.rs;
        src_en[0]  = cons.src_rs;
        src_reg[1] = cons.rt;
        src_en[1]  = cons.src_rt;
    end

    // One comparator per source operand.
    for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
        assign hit[g] = src_en[g] && (src_reg[g] == prod.rt);
    end

    // Combine: only a load with a nonzero destination can cause a hazard.
    always_comb begin
        hazard = prod.is_load && (prod.rt != '0) && (|hit);
    end
endmodule

// File: rtl/ldu_interlock.sv
// Top: load-use interlock. Decodes the ID/EX and IF/ID instruction copies,
// detects a load-use hazard and issues a one-cycle stall plus bubble.
// Assumes a surrounding pipeline that puts a bubble in ID/EX after a stall;
// the registered flag enforces the single-cycle stall independently of that.
module ldu_interlock
    import ldu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] ifid_instr,
    input  logic [INSTR_W-1:0] idex_instr,
    output logic               pc_write,
    output logic               ifid_write,
    output logic               idex_bubble
);
    dec_t prod_d, cons_d;
    logic hazard;
    logic stall;
    logic stalled_q;

    ldu_decode u_dec_prod (.instr(idex_instr), .dec(prod_d));
    ldu_decode u_dec_cons (.instr(ifid_instr), .dec(cons_d));

    ldu_match #(.N_SRC(2)) u_match (
        .prod   (prod_d),
        .cons   (cons_d),
        .hazard (hazard)
    );

    // Stall only out of reset and not in the cycle right after a stall.
    always_comb begin
        stall = rst_n && hazard && !stalled_q;
    end

    // Remember that the previous cycle stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) stalled_q <= 1'b0;
        else        stalled_q <= stall;
    end

    // Drive the pipeline controls from the stall decision.
    always_comb begin
        pc_write    = !stall;
        ifid_write  = !stall;
        idex_bubble = stall;
    end
endmodule

// File: rtl/ldu_checker.sv
// Checker: properties of the interlock outputs, decoding fields from the
// ports on its own. Bound to every ldu_interlock instance.
module ldu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ifid_instr,
    input logic [31:0] idex_instr,
    input logic        pc_write,
    input logic        ifid_write,
    input logic        idex_bubble
);
    logic [5:0] p_op, c_op;
    logic       c_reads_rs;
    always_comb begin
        p_op = idex_instr[31:26];
        c_op = ifid_instr[31:26];
        c_reads_rs = (c_op == 6'h00) || (c_op == 6'h04) || (c_op == 6'h05) ||
                     (c_op >= 6'h08 && c_op <= 6'h0F) || (c_op == 6'h23) || (c_op == 6'h2B);
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (pc_write && !idex_bubble)); // R1
    AST_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (p_op != 6'h23) |-> !idex_bubble); // R2
    AST_RS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (p_op == 6'h23 && idex_instr[20:16] != 5'd0 && c_reads_rs &&
         ifid_instr[25:21] == idex_instr[20:16] && !$past(idex_bubble)) |-> idex_bubble); // R3
    AST_ZERO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_instr[20:16] == 5'd0) |-> !idex_bubble); // R6
    AST_OUT_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_write == ifid_write) && (idex_bubble == !pc_write)); // R7
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |=> !idex_bubble); // R8
endmodule

bind ldu_interlock ldu_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ifid_instr(ifid_instr), .idex_instr(idex_instr),
    .pc_write(pc_write), .ifid_write(ifid_write), .idex_bubble(idex_bubble)
);

// File: tb/sim_ldu_interlock.sv
// Bench for ldu_interlock: vector table walk, then directed reset and
// single-cycle-stall tests.
module sim_ldu_interlock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ifid_instr = '0;
    logic [31:0] idex_instr = '0;
    logic        pc_write, ifid_write, idex_bubble;
    int          n_run = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    ldu_interlock u0 (
        .clk(clk), .rst_n(rst_n), .ifid_instr(ifid_instr), .idex_instr(idex_instr),
        .pc_write(pc_write), .ifid_write(ifid_write), .idex_bubble(idex_bubble)
    );

    // entry: {idex[31:0], ifid[31:0], expected stall, requirement number}
    localparam int NV = 20;
    localparam logic [72:0] VEC [NV] = '{
        {32'h8C250000, 32'h00A21820, 1'b1, 8'd3}, // R3 R-type rs
        {32'h8C250000, 32'h00451820, 1'b1, 8'd4}, // R4 R-type rt
        {32'h8C250000, 32'h00431820, 1'b0, 8'd3}, // R3 R-type no match
        {32'h8C250000, 32'h20A70004, 1'b1, 8'd3}, // R3 addi rs
        {32'h8C250000, 32'h20450004, 1'b0, 8'd5}, // R5 addi rt is destination
        {32'h8C250000, 32'h3CA60001, 1'b1, 8'd3}, // R3 top of immediate range
        {32'h8C250000, 32'hAC450008, 1'b1, 8'd4}, // R4 store data rt
        {32'h8C250000, 32'hACA20008, 1'b1, 8'd3}, // R3 store base rs
        {32'h8C250000, 32'h10650002, 1'b1, 8'd4}, // R4 branch rt
        {32'h8C250000, 32'h14A30002, 1'b1, 8'd3}, // R3 bne rs
        {32'h8C250000, 32'h8CA80000, 1'b1, 8'd3}, // R3 load consumer rs
        {32'h8C250000, 32'h8C450000, 1'b0, 8'd5}, // R5 load consumer rt
        {32'h8C250000, 32'h08A50000, 1'b0, 8'd9}, // R9 jump opcode
        {32'h8C250000, 32'h1CA50000, 1'b0, 8'd9}, // R9 opcode 0x07
        {32'h8C250000, 32'h40A50000, 1'b0, 8'd9}, // R9 opcode 0x10
        {32'hAC250000, 32'h00A21820, 1'b0, 8'd2}, // R2 store producer
        {32'h00250000, 32'h00A21820, 1'b0, 8'd2}, // R2 R-type producer
        {32'h00250023, 32'h00A21820, 1'b0, 8'd2}, // R2 0x23 in low bits only
        {32'h8C200000, 32'h00001820, 1'b0, 8'd6}, // R6 load to register 0
        {32'h8C200000, 32'hAC000000, 1'b0, 8'd6}  // R6 store reading r0
    };

    task automatic check(input bit exp_stall, input string req);
        n_run++;
        if (pc_write !== !exp_stall || ifid_write !== !exp_stall || idex_bubble !== exp_stall) begin
            n_fail++;
            $display("FAIL %s: pc_write=%b ifid_write=%b idex_bubble=%b expected %b %b %b",
                     req, pc_write, ifid_write, idex_bubble, !exp_stall, !exp_stall, exp_stall);
        end
    endtask

    initial begin : watchdog
        #100000;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected end before timeout");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: hazard inputs during reset show no stall.
        idex_instr = 32'h8C250000;
        ifid_instr = 32'h00A21820;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check(1'b0, "R1 reset hides hazard");
        rst_n = 1'b1;
        ifid_instr = '0; idex_instr = '0;
        @(negedge clk); #1;
        check(1'b0, "R1 idle after reset");

        // Table walk: each vector followed by one neutral cycle.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idex_instr = VEC[i][72:41];
            ifid_instr = VEC[i][40:9];
            #1;
            check(VEC[i][8], $sformatf("R%0d vector %0d", VEC[i][7:0], i));
            @(negedge clk);
            idex_instr = '0; ifid_instr = '0;
        end

        // R8: held hazard stalls, then is released, then stalls again.
        @(negedge clk);
        idex_instr = 32'h8C250000;
        ifid_instr = 32'h00A21820;
        #1; check(1'b1, "R8 first stall cycle");
        @(negedge clk); #1; check(1'b0, "R8 cycle after stall");
        @(negedge clk); #1; check(1'b1, "R8 stall again");
        // R7: outputs after a plain non-hazard.
        @(negedge clk);
        ifid_instr = 32'h00431820;
        #1; check(1'b0, "R7 no stall outputs");

        // R1: reset reasserted mid-run clears stall state and hides hazard.
        @(negedge clk);
        rst_n = 1'b0;
        ifid_instr = 32'h00A21820;
        #1; check(1'b0, "R1 reset reasserted");
        @(negedge clk);
        rst_n = 1'b1;
        #1; check(1'b1, "R1 stall resumes after reset");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule